// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt inputs and turns them into two request lines and one wake signal. Each input is first brought into the controller's clock domain. It is then judged against a three-bit trigger code chosen for that input: disabled, rising edge, falling edge, either edge, active-high level or active-low level. Edge events are latched into a pending bit that stays set until software acknowledges it. Level sources show their pending state for as long as the level is active.

Software reaches the controller through a small memory-mapped register file. Every control register has a write-one-to-set address and a write-one-to-clear address, so single bits can be changed without a read-modify-write. The three trigger-code bits of a source live in three separate registers. A routing register sends each source to request line 0 or line 1. Enabling a source sets its wake enable along with its mask bit. Only the lowest eight sources can ever hold a wake enable.

Top module: `trig_intc`

## Requirements
- R1: After synchronous reset every register reads 0, `irq_req` is 2'b00 and `wake_out` is 0.
- R2: The register index is `bus_addr[3:1]` (0 enable, 1 wake, 2 code bit 0, 3 code bit 1, 4 code bit 2, 5 route, 6 pending). With `bus_addr[0]`=0 a write sets the bits written as 1, and with `bus_addr[0]`=1 it clears them. Bits written as 0 are left unchanged.
- R3: A set-write to the enable register also sets the wake bits for the same sources. A clear-write to the enable register also clears them.
- R4: Wake bits for sources 8 and above always read 0 and never drive `wake_out`.
- R5: The trigger code of source i is {code bit 2, code bit 1, code bit 0}. Codes 000, 100 and 111 never produce a pending bit.
- R6: Code 001 latches pending on a rising input, 010 on a falling input and 011 on either edge. The latched bit stays set after the input returns.
- R7: A write of 1 to a bit at either pending address clears that edge-latched bit. Pending bits written as 0 are kept. If an edge arrives in the same cycle as the acknowledge, the pending bit stays set.
- R8: Code 101 shows pending while the input is high, and code 110 while it is low. The pending bit drops when the level goes inactive.
- R9: `irq_req[k]` is high when some source is pending and enabled and its route bit equals k.
- R10: `wake_out` is high when some source among 0..7 is pending and has its wake bit set.
- R11: Reads are combinational from `bus_addr` and return the current register value at either address of the pair. Index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register index in [3:1]; bit 0 selects clear (1) or set (0) |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_in | input | 32 | Asynchronous interrupt inputs |
| irq_req | output | 2 | Request lines 0 and 1 |
| wake_out | output | 1 | Wake request from sources 0..7 |

## Verification
The bench builds the controller with its default 32 sources and 8 wake-capable sources. This gives both a wake-capable source (3) and a source above the wake range (20), and both are checked against the wake limit and the routing register. A vector table steps one source through all eight trigger codes. For each code it drives an input transition and then the return transition, so latched edges, level tracking and the disabled codes are all checked against the pending register, the request line and the wake output. Directed tests then cover the set/clear semantics, the coupling between enable and wake, partial acknowledges and a reset in the middle of a run.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

    localparam int NLINE = 2;

    typedef enum logic [2:0] {
        RI_ENABLE = 3'd0,
        RI_WAKE   = 3'd1,
        RI_CODE0  = 3'd2,
        RI_CODE1  = 3'd3,
        RI_CODE2  = 3'd4,
        RI_ROUTE  = 3'd5,
        RI_PEND   = 3'd6,
        RI_NONE   = 3'd7
    } reg_idx_e;

    typedef enum logic [2:0] {
        TM_OFF,
        TM_RISE,
        TM_FALL,
        TM_BOTH,
        TM_HIGH,
        TM_LOW
    } trig_mode_e;

    function automatic trig_mode_e decode_trig(input logic [2:0] code);
        case (code)
            3'b001:  return TM_RISE;
            3'b010:  return TM_FALL;
            3'b011:  return TM_BOTH;
            3'b101:  return TM_HIGH;
            3'b110:  return TM_LOW;
            default: return TM_OFF;
        endcase
    endfunction

    function automatic logic is_edge_mode(input trig_mode_e m);
        return (m == TM_RISE) || (m == TM_FALL) || (m == TM_BOTH);
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import trig_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NWAKE = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [3:0]      bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] enable_q,
    output logic [NSRC-1:0] wake_q,
    output logic [NSRC-1:0] code0_q,
    output logic [NSRC-1:0] code1_q,
    output logic [NSRC-1:0] code2_q,
    output logic [NSRC-1:0] route_q,
    output logic [NSRC-1:0] ack
);

    localparam logic [NSRC-1:0] WAKE_OK = NSRC'((64'd1 << NWAKE) - 64'd1);

    reg_idx_e idx;
    logic     is_clr;
    assign idx    = reg_idx_e'(bus_addr[3:1]);
    assign is_clr = bus_addr[0];

    function automatic logic [NSRC-1:0] upd(input logic [NSRC-1:0] cur,
                                             input logic [NSRC-1:0] wd,
                                             input logic clr);
        return clr ? (cur & ~wd) : (cur | wd);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            wake_q   <= '0;
            code0_q  <= '0;
            code1_q  <= '0;
            code2_q  <= '0;
            route_q  <= '0;
        end else if (bus_wr) begin
            case (idx)
                RI_ENABLE: begin
                    enable_q <= upd(enable_q, bus_wdata, is_clr);
                    wake_q   <= upd(wake_q, bus_wdata & WAKE_OK, is_clr);
                end
                RI_WAKE:  wake_q  <= upd(wake_q, bus_wdata & WAKE_OK, is_clr);
                RI_CODE0: code0_q <= upd(code0_q, bus_wdata, is_clr);
                RI_CODE1: code1_q <= upd(code1_q, bus_wdata, is_clr);
                RI_CODE2: code2_q <= upd(code2_q, bus_wdata, is_clr);
                RI_ROUTE: route_q <= upd(route_q, bus_wdata, is_clr);
                default: ;
            endcase
        end
    end

    assign ack = (bus_wr && idx == RI_PEND) ? bus_wdata : '0;

    always_comb begin
        case (idx)
            RI_ENABLE: bus_rdata = enable_q;
            RI_WAKE:   bus_rdata = wake_q;
            RI_CODE0:  bus_rdata = code0_q;
            RI_CODE1:  bus_rdata = code1_q;
            RI_CODE2:  bus_rdata = code2_q;
            RI_ROUTE:  bus_rdata = route_q;
            RI_PEND:   bus_rdata = pend;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_src_detect.sv
module intc_src_detect
    import trig_intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [2:0] code,
    input  logic       ack,
    output logic       pend
);

    logic       sync1, level, prev, latch;
    logic       evt;
    trig_mode_e mode;

    assign mode = decode_trig(code);

    always_comb begin
        case (mode)
            TM_RISE: evt = level & ~prev;
            TM_FALL: evt = ~level & prev;
            TM_BOTH: evt = level ^ prev;
            default: evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            level <= 1'b0;
            prev  <= 1'b0;
            latch <= 1'b0;
        end else begin
            sync1 <= pin;
            level <= sync1;
            prev  <= level;
            // an event in the acknowledge cycle keeps the bit set
            latch <= is_edge_mode(mode) ? ((latch & ~ack) | evt) : 1'b0;
        end
    end

    always_comb begin
        case (mode)
            TM_HIGH: pend = level;
            TM_LOW:  pend = ~level;
            TM_OFF:  pend = 1'b0;
            default: pend = latch;
        endcase
    end

endmodule

// File: rtl/intc_combine.sv
module intc_combine
    import trig_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NWAKE = 8
) (
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  enable_q,
    input  logic [NSRC-1:0]  wake_q,
    input  logic [NSRC-1:0]  route_q,
    output logic [NLINE-1:0] irq_req,
    output logic             wake_out
);

    logic [NSRC-1:0] live;
    assign live = pend & enable_q;

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        logic [NSRC-1:0] sel;
        assign sel        = (k == 0) ? ~route_q : route_q;
        assign irq_req[k] = |(live & sel);
    end

    assign wake_out = |(pend[NWAKE-1:0] & wake_q[NWAKE-1:0]);

endmodule

// File: rtl/trig_intc.sv
module trig_intc
    import trig_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NWAKE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    input  logic [NSRC-1:0]  src_in,
    output logic [NLINE-1:0] irq_req,
    output logic             wake_out
);

    logic [NSRC-1:0] enable_q, wake_q, code0_q, code1_q, code2_q, route_q;
    logic [NSRC-1:0] pend, ack;

    intc_regfile #(.NSRC(NSRC), .NWAKE(NWAKE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .enable_q  (enable_q),
        .wake_q    (wake_q),
        .code0_q   (code0_q),
        .code1_q   (code1_q),
        .code2_q   (code2_q),
        .route_q   (route_q),
        .ack       (ack)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        intc_src_detect u_det (
            .clk  (clk),
            .rst  (rst),
            .pin  (src_in[i]),
            .code ({code2_q[i], code1_q[i], code0_q[i]}),
            .ack  (ack[i]),
            .pend (pend[i])
        );
    end

    intc_combine #(.NSRC(NSRC), .NWAKE(NWAKE)) u_comb (
        .pend     (pend),
        .enable_q (enable_q),
        .wake_q   (wake_q),
        .route_q  (route_q),
        .irq_req  (irq_req),
        .wake_out (wake_out)
    );

endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk
    import trig_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NWAKE = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [NSRC-1:0]  bus_wdata,
    input logic [NSRC-1:0]  enable_q,
    input logic [NSRC-1:0]  wake_q,
    input logic [NSRC-1:0]  code0_q,
    input logic [NSRC-1:0]  code1_q,
    input logic [NSRC-1:0]  code2_q,
    input logic [NSRC-1:0]  pend,
    input logic [NLINE-1:0] irq_req,
    input logic             wake_out
);

    logic [NSRC-1:0] off_vec;
    always_comb begin
        for (int i = 0; i < NSRC; i++)
            off_vec[i] = (decode_trig({code2_q[i], code1_q[i], code0_q[i]}) == TM_OFF);
    end

    logic en_set_wr, en_clr_wr, c0_clr_wr;
    assign en_set_wr = bus_wr && bus_addr == 4'd0;
    assign en_clr_wr = bus_wr && bus_addr == 4'd1;
    assign c0_clr_wr = bus_wr && bus_addr == 4'd5;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enable_q == '0 && wake_q == '0 && code0_q == '0 && irq_req == '0));

    // R2
    a_r2_clear_write: assert property (@(posedge clk) disable iff (rst)
        c0_clr_wr |=> ((code0_q & $past(bus_wdata)) == '0));

    // R3
    a_r3_enable_set: assert property (@(posedge clk) disable iff (rst)
        en_set_wr |=> ((enable_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_disable_clears_wake: assert property (@(posedge clk) disable iff (rst)
        en_clr_wr |=> ((wake_q & $past(bus_wdata)) == '0));

    // R4
    a_r4_high_wake_zero: assert property (@(posedge clk) disable iff (rst)
        wake_q[NSRC-1:NWAKE] == '0);

    // R5
    a_r5_off_no_pend: assert property (@(posedge clk) disable iff (rst)
        (pend & off_vec) == '0);

    // R9
    a_r9_req_needs_live: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |-> ((pend & enable_q) != '0));

    // R10
    a_r10_wake_source: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> ((pend[NWAKE-1:0] & wake_q[NWAKE-1:0]) != '0));

endmodule

bind trig_intc trig_intc_chk #(.NSRC(NSRC), .NWAKE(NWAKE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .enable_q  (enable_q),
    .wake_q    (wake_q),
    .code0_q   (code0_q),
    .code1_q   (code1_q),
    .code2_q   (code2_q),
    .pend      (pend),
    .irq_req   (irq_req),
    .wake_out  (wake_out)
);

// File: tb/trig_intc_tb.sv
`timescale 1ns/1ps
module trig_intc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic [1:0]  irq_req;
    logic        wake_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trig_intc u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_req   (irq_req),
        .wake_out  (wake_out)
    );

    localparam logic [3:0] A_EN = 4'd0, A_WK = 4'd2, A_C0 = 4'd4, A_C1 = 4'd6,
                           A_C2 = 4'd8, A_RT = 4'd10, A_PD = 4'd12;

    // {code[2:0], level_a, level_b, exp_pend_at_b, exp_pend_back_at_a}
    localparam logic [6:0] VEC [0:13] = '{
        {3'b001, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'b001, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'b010, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'b011, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'b101, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'b101, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'b110, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'b110, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b000, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b000, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b100, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b111, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic set_code(int s, logic [2:0] c);
        wr(A_C0 + 4'd1, 32'h1 << s);
        wr(A_C1 + 4'd1, 32'h1 << s);
        wr(A_C2 + 4'd1, 32'h1 << s);
        if (c[0]) wr(A_C0, 32'h1 << s);
        if (c[1]) wr(A_C1, 32'h1 << s);
        if (c[2]) wr(A_C2, 32'h1 << s);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a += 2) begin
            rd(a[3:0], d);
            check("R1 reset reg", d, 32'h0);
        end
        check("R1 irq_req", {30'd0, irq_req}, 32'h0);
        check("R1 wake_out", {31'd0, wake_out}, 32'h0);

        // R2: set / clear semantics
        wr(A_RT, 32'h0000_00F0);
        wr(A_RT, 32'h0);
        rd(A_RT, d); check("R2 set", d, 32'h0000_00F0);
        wr(A_RT + 4'd1, 32'h0000_0030);
        rd(A_RT, d); check("R2 clear", d, 32'h0000_00C0);
        wr(A_RT + 4'd1, 32'h0);
        rd(A_RT + 4'd1, d); check("R2 zero clear / R11 odd addr read", d, 32'h0000_00C0);
        wr(A_RT + 4'd1, 32'hFFFF_FFFF);

        // R3 / R4: enable couples wake, wake limit
        wr(A_EN, 32'h0000_0104);
        rd(A_EN, d); check("R3 enable set", d, 32'h0000_0104);
        rd(A_WK, d); check("R3 R4 wake follows enable", d, 32'h0000_0004);
        wr(A_EN + 4'd1, 32'h0000_0004);
        rd(A_WK, d); check("R3 wake cleared by disable", d, 32'h0);
        rd(A_EN, d); check("R3 enable clear", d, 32'h0000_0100);
        wr(A_WK, 32'hFFFF_FFFF);
        rd(A_WK, d); check("R4 wake upper bits", d, 32'h0000_00FF);
        wr(A_WK + 4'd1, 32'hFFFF_FFFF);
        wr(A_EN + 4'd1, 32'hFFFF_FFFF);

        // R11: unused index reads zero
        rd(4'd14, d); check("R11 unused index", d, 32'h0);
        rd(4'd15, d); check("R11 unused index clr", d, 32'h0);

        // R5 R6 R8 R9 R10: trigger-mode table on source 3
        wr(A_EN, 32'h0000_0008);
        for (int v = 0; v < 14; v++) begin
            logic [2:0] c;
            logic la, lb, eb, ek;
            {c, la, lb, eb, ek} = VEC[v];
            set_code(3, c);
            src_in[3] = la;
            settle();
            wr(A_PD, 32'h0000_0008);
            src_in[3] = lb;
            settle();
            rd(A_PD, d);
            check($sformatf("R5 R6 R8 pend code=%b vec=%0d", c, v), {31'd0, d[3]}, {31'd0, eb});
            check($sformatf("R9 irq_req vec=%0d", v), {30'd0, irq_req}, {31'd0, eb});
            check($sformatf("R10 wake_out vec=%0d", v), {31'd0, wake_out}, {31'd0, eb});
            src_in[3] = la;
            settle();
            rd(A_PD, d);
            check($sformatf("R6 R8 pend back vec=%0d", v), {31'd0, d[3]}, {31'd0, ek});
            set_code(3, 3'b000);
            src_in[3] = 1'b0;
            settle();
        end
        wr(A_EN + 4'd1, 32'h0000_0008);

        // R9 / R4: routing on source 20 (beyond wake range)
        set_code(20, 3'b101);
        wr(A_EN, 32'h0010_0000);
        wr(A_RT, 32'h0010_0000);
        src_in[20] = 1'b1;
        settle();
        check("R9 route line1", {30'd0, irq_req}, 32'h2);
        check("R4 R10 no wake above 7", {31'd0, wake_out}, 32'h0);
        wr(A_RT + 4'd1, 32'h0010_0000);
        check("R9 route line0", {30'd0, irq_req}, 32'h1);
        wr(A_EN + 4'd1, 32'h0010_0000);
        check("R9 masked source", {30'd0, irq_req}, 32'h0);
        src_in[20] = 1'b0;
        set_code(20, 3'b000);

        // R7: partial acknowledge
        set_code(1, 3'b001);
        set_code(2, 3'b001);
        src_in[2:1] = 2'b11;
        settle();
        rd(A_PD, d); check("R7 both pending", d, 32'h0000_0006);
        wr(A_PD + 4'd1, 32'h0000_0002);
        rd(A_PD, d); check("R7 ack one", d, 32'h0000_0004);
        wr(A_PD, 32'h0);
        rd(A_PD, d); check("R7 zero ack keeps", d, 32'h0000_0004);
        wr(A_PD, 32'h0000_0004);
        settle();
        rd(A_PD, d); check("R7 ack at set addr", d, 32'h0);

        // R1: reset in mid-run
        wr(A_EN, 32'h0000_00FF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_EN, d); check("R1 mid reset enable", d, 32'h0);
        rd(A_C0, d); check("R1 mid reset code", d, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule